// File: doc/BRIEF.md
# Byte-Laned Static RAM Emulator

This block is a clocked stand-in for an asynchronous 16-bit static RAM with active-low controls. It lets a system testbench or an FPGA prototype hold a memory target whose pin behaviour follows the usual static RAM truth table. The controls are chip select, write strobe, output enable and a pair of byte-lane enables. The bidirectional data pins are split into a write-data input, a read-data output, and one drive flag per byte lane. A lane drives the pins only while its drive flag is high.

All controls are evaluated against the rising clock edge. A write lasts while chip select, write strobe and a lane's enable are all low. It commits to storage when that overlap ends, and it stores the address and data captured on the last edge before the end. A read drives only the enabled lanes, and it raises a valid flag once the address and controls have stayed unchanged for a configurable number of clock edges. The address width defaults to 10 bits so that the default build stays small. Setting it to 18 gives the full 262,144-word array.

Top module: `sram_emu_top`

## Requirements
- R1: Each word is 16 bits; `addrIn` (ADDR_W bits, default 10) selects one of 2^ADDR_W words, and a full-word write followed by a full-word read of the same address returns the written word.
- R2: While `selN` is high, both drive flags are low, `rdData` is zero, and no storage changes, whatever the other controls and data do.
- R3: With `selN` low, `wrN` high and `oeN` high, both drive flags stay low and `rdValid` stays low.
- R4: A read (`selN` low, `wrN` high, `oeN` low) raises `driveLo` only when `loN` is low, which covers bits 7:0, and `driveHi` only when `hiN` is low, which covers bits 15:8; a lane that is not driven reads as zero on `rdData`.
- R5: With `selN` and `wrN` low, each lane whose enable is low is written, whatever `oeN` is; a lane whose enable is high keeps its stored byte.
- R6: With `selN` low and both lane enables high, no lane is driven and no lane is written.
- R7: A lane's write commits on the first rising edge at which any of `selN`, `wrN` or that lane's enable is high. It stores the address and data sampled at the last edge on which all three were low, so lanes that end at different edges keep different data.
- R8: When `wrN` returns high while `selN` and `oeN` stay low, the enabled lanes drive again and show the current address's contents, including the data just written.
- R9: `rdValid` is high only during a read, and only once LAT rising edges (default 2, LAT at least 1) have passed since the last change of address or of any control; any such change drops it in the same cycle.
- R10: Pulling `wrN` low while `selN` and `oeN` are low drops both drive flags in the same cycle, before the next clock edge.
- R11: Reset clears the control state (`rdValid` low, no pending write) but leaves storage contents undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| addrIn | input | ADDR_W | Word address |
| selN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| loN | input | 1 | Lower-lane enable (bits 7:0), active low |
| hiN | input | 1 | Upper-lane enable (bits 15:8), active low |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, zero in lanes not driven |
| driveLo | output | 1 | Lower lane drives the pins |
| driveHi | output | 1 | Upper lane drives the pins |
| rdValid | output | 1 | Read data has settled for the current address and controls |

## Verification
The assertions assume that the controls and address change only between clock edges, so that every edge sees one settled value. They also assume the caller keeps the address steady for as long as a write overlap is open, as a real part demands. The bench changes inputs only on falling edges and moves the address only while no write overlap is active. It writes every location before reading it, and it checks each result against a shadow copy with lane masking applied.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Per-lane strobes handed from the control to the datapath.
  typedef struct packed {
    logic [LANES-1:0] capture;  // overlap active this edge: latch address and data
    logic [LANES-1:0] commit;   // overlap ended this edge: write the latched byte
    logic [LANES-1:0] drive;    // lane drives the read pins
  } laneStrobes_t;

endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selN,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              loN,
  input  logic              hiN,
  output laneStrobes_t      strobes,
  output logic              rdValid
);

  localparam int VEC_W = ADDR_W + 5;
  localparam int CNT_W = $clog2(LAT + 1) + 1;

  logic [LANES-1:0] laneSel;
  logic [LANES-1:0] wrAct;
  logic [LANES-1:0] wrActPrev;
  logic [LANES-1:0] commitV;
  logic [LANES-1:0] driveV;

  assign laneSel = {~hiN, ~loN};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrAct[g]   = ~selN & ~wrN & laneSel[g];
    assign commitV[g] = wrActPrev[g] & ~wrAct[g];
    assign driveV[g]  = ~selN & wrN & ~oeN & laneSel[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrActPrev <= '0;
    else       wrActPrev <= wrAct;
  end

  assign strobes = '{capture: wrAct, commit: commitV, drive: driveV};

  // Settling counter: restarts on any change of address or control.
  logic [VEC_W-1:0] ctrlVec;
  logic [VEC_W-1:0] prevVec;
  logic [CNT_W-1:0] settleCnt;
  logic             changed;

  assign ctrlVec = {addrIn, selN, wrN, oeN, loN, hiN};
  assign changed = (ctrlVec != prevVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevVec   <= '1;
      settleCnt <= '0;
    end else begin
      prevVec <= ctrlVec;
      if (changed)                        settleCnt <= CNT_W'(1);
      else if (settleCnt < CNT_W'(LAT))   settleCnt <= settleCnt + 1'b1;
    end
  end

  assign rdValid = (|driveV) & ~changed & (settleCnt >= CNT_W'(LAT));

endmodule

// File: rtl/sram_emu_datapath.sv
module sram_emu_datapath
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  laneStrobes_t      strobes,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [ADDR_W-1:0] holdAddr;
    logic [LANE_W-1:0] holdData;
    logic [LANE_W-1:0] rdReg;
    logic [LANE_W-1:0] rdNext;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdAddr <= '0;
        holdData <= '0;
      end else if (strobes.capture[g]) begin
        holdAddr <= addrIn;
        holdData <= wrData[g*LANE_W +: LANE_W];
      end
    end

    // Storage is not reset.
    always_ff @(posedge clk) begin
      if (strobes.commit[g]) laneMem[holdAddr] <= holdData;
    end

    // Forward a byte committed on this edge to the same address.
    assign rdNext = (strobes.commit[g] && holdAddr == addrIn) ? holdData : laneMem[addrIn];

    always_ff @(posedge clk) rdReg <= rdNext;

    assign rdData[g*LANE_W +: LANE_W] = strobes.drive[g] ? rdReg : '0;
  end

endmodule

// File: rtl/sram_emu_top.sv
module sram_emu_top
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selN,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              loN,
  input  logic              hiN,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              driveLo,
  output logic              driveHi,
  output logic              rdValid
);

  laneStrobes_t strobes;

  sram_emu_ctrl #(.ADDR_W(ADDR_W), .LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selN(selN), .wrN(wrN),
    .oeN(oeN), .loN(loN), .hiN(hiN), .strobes(strobes), .rdValid(rdValid)
  );

  sram_emu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrData(wrData),
    .strobes(strobes), .rdData(rdData)
  );

  assign driveLo = strobes.drive[0];
  assign driveHi = strobes.drive[1];

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              selN,
  input logic              wrN,
  input logic              oeN,
  input logic [15:0]       rdData,
  input logic              driveLo,
  input logic              driveHi,
  input logic              rdValid
);

  a_r2_deselect_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> (!driveLo && !driveHi && rdData == 16'h0));

  a_r3_oe_high_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && wrN && oeN) |-> (!driveLo && !driveHi && !rdValid));

  a_r4_undriven_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!driveLo |-> rdData[7:0] == 8'h0) and (!driveHi |-> rdData[15:8] == 8'h0));

  a_r10_write_blocks_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !wrN) |-> (!driveLo && !driveHi));

  a_r9_valid_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (driveLo || driveHi));

  a_r9_valid_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $stable(addrIn));

endmodule

bind sram_emu_top sram_emu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrIn(addrIn), .selN(selN), .wrN(wrN), .oeN(oeN),
  .rdData(rdData), .driveLo(driveLo), .driveHi(driveHi), .rdValid(rdValid)
);

// File: tb/tb_sram_emu_top.sv
module tb_sram_emu_top;
  localparam int ADDR_W = 10;
  localparam int LAT    = 2;
  localparam int CLK_NS = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              selN = 1'b1, wrN = 1'b1, oeN = 1'b1, loN = 1'b1, hiN = 1'b1;
  logic [15:0]       wrData = '0;
  logic [15:0]       rdData;
  logic              driveLo, driveHi, rdValid;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [1 << ADDR_W];

  always #(CLK_NS/2) clk = ~clk;

  sram_emu_top #(.ADDR_W(ADDR_W), .LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selN(selN), .wrN(wrN), .oeN(oeN),
    .loN(loN), .hiN(hiN), .wrData(wrData), .rdData(rdData),
    .driveLo(driveLo), .driveHi(driveHi), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    selN = 1'b1; wrN = 1'b1; oeN = 1'b1; loN = 1'b1; hiN = 1'b1;
  endtask

  // Full write cycle ended by wrN rising; updates shadow per lane.
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                         input logic lo, input logic hi, input logic oe);
    @(negedge clk);
    addrIn = a; wrData = d; selN = 1'b0; wrN = 1'b0; loN = lo; hiN = hi; oeN = oe;
    @(negedge clk);
    wrN = 1'b1;
    @(posedge clk);
    if (!lo) shadow[a][7:0]  = d[7:0];
    if (!hi) shadow[a][15:8] = d[15:8];
    idle();
  endtask

  task automatic checkRead(input string req, input logic [ADDR_W-1:0] a,
                           input logic lo, input logic hi);
    logic [15:0] exp;
    exp = {hi ? 8'h00 : shadow[a][15:8], lo ? 8'h00 : shadow[a][7:0]};
    @(negedge clk);
    addrIn = a; selN = 1'b0; wrN = 1'b1; oeN = 1'b0; loN = lo; hiN = hi;
    #1 check({req, " valid low after change"}, rdValid, 1'b0);
    repeat (LAT) @(posedge clk);
    #2;
    check({req, " valid"}, rdValid, (lo && hi) ? 1'b0 : 1'b1);
    check({req, " drives"}, {driveHi, driveLo}, {~hi, ~lo});
    check({req, " data"}, rdData, exp);
    idle();
  endtask

  task automatic t_reset();
    #2 check("R11 reset valid", rdValid, 1'b0);
    check("R11 reset drives", {driveHi, driveLo}, 2'b00);
    check("R2 reset data", rdData, 16'h0);
  endtask

  task automatic t_fullWords();
    doWrite(10'h001, 16'hA55A, 1'b0, 1'b0, 1'b1);
    doWrite(10'h3FF, 16'h1234, 1'b0, 1'b0, 1'b1);
    doWrite(10'h000, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    checkRead("R1 word 001", 10'h001, 1'b0, 1'b0);
    checkRead("R1 word 3FF", 10'h3FF, 1'b0, 1'b0);
    checkRead("R1 word 000", 10'h000, 1'b0, 1'b0);
  endtask

  task automatic t_laneWrites();
    doWrite(10'h001, 16'h77C3, 1'b0, 1'b1, 1'b1);  // lower only
    checkRead("R5 lower lane write", 10'h001, 1'b0, 1'b0);
    doWrite(10'h3FF, 16'h9E00, 1'b1, 1'b0, 1'b0);  // upper only, oeN low
    checkRead("R5 upper lane write oe low", 10'h3FF, 1'b0, 1'b0);
  endtask

  task automatic t_laneReads();
    checkRead("R4 lower only read", 10'h001, 1'b0, 1'b1);
    checkRead("R4 upper only read", 10'h3FF, 1'b1, 1'b0);
  endtask

  task automatic t_bothHigh();
    @(negedge clk);
    addrIn = 10'h001; wrData = 16'h0BAD; selN = 1'b0; wrN = 1'b0; loN = 1'b1; hiN = 1'b1;
    @(negedge clk); @(negedge clk);
    wrN = 1'b1;
    @(posedge clk);
    idle();
    checkRead("R6 no lane written", 10'h001, 1'b0, 1'b0);
    checkRead("R6 no lane driven", 10'h001, 1'b1, 1'b1);
  endtask

  task automatic t_deselect();
    @(negedge clk);
    addrIn = 10'h000; wrData = 16'h5150; selN = 1'b1; wrN = 1'b0; oeN = 1'b0; loN = 1'b0; hiN = 1'b0;
    #1 check("R2 deselect drives", {driveHi, driveLo}, 2'b00);
    @(negedge clk); @(negedge clk);
    check("R2 deselect data", rdData, 16'h0);
    check("R2 deselect valid", rdValid, 1'b0);
    wrN = 1'b1;
    @(negedge clk);
    idle();
    checkRead("R2 storage unchanged", 10'h000, 1'b0, 1'b0);
  endtask

  task automatic t_outDisabled();
    @(negedge clk);
    addrIn = 10'h001; selN = 1'b0; wrN = 1'b1; oeN = 1'b1; loN = 1'b0; hiN = 1'b0;
    repeat (LAT + 2) @(posedge clk);
    #2;
    check("R3 output disabled drives", {driveHi, driveLo}, 2'b00);
    check("R3 output disabled valid", rdValid, 1'b0);
    idle();
  endtask

  task automatic t_lastData();
    @(negedge clk);
    addrIn = 10'h055; wrData = 16'h1111; selN = 1'b0; wrN = 1'b0; loN = 1'b0; hiN = 1'b0;
    @(negedge clk);
    wrData = 16'h2222;
    @(negedge clk);
    selN = 1'b1;                       // select ends the overlap
    wrData = 16'h3333;
    @(posedge clk);
    shadow[10'h055] = 16'h2222;
    idle();
    checkRead("R7 last sampled data", 10'h055, 1'b0, 1'b0);
  endtask

  task automatic t_laneEnd();
    @(negedge clk);
    addrIn = 10'h0AA; wrData = 16'hD1D1; selN = 1'b0; wrN = 1'b0; loN = 1'b0; hiN = 1'b0;
    @(negedge clk);
    hiN = 1'b1; wrData = 16'hE2E2;     // upper overlap ends first
    @(negedge clk);
    wrN = 1'b1; wrData = 16'hF3F3;
    @(posedge clk);
    shadow[10'h0AA] = 16'hD1E2;
    idle();
    checkRead("R7 lanes end apart", 10'h0AA, 1'b0, 1'b0);
  endtask

  task automatic t_writeThenRead();
    @(negedge clk);
    addrIn = 10'h123; selN = 1'b0; wrN = 1'b1; oeN = 1'b0; loN = 1'b0; hiN = 1'b0;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    wrN = 1'b0; wrData = 16'hC0DE;
    #1 check("R10 drive drops with write", {driveHi, driveLo}, 2'b00);
    @(negedge clk);
    wrN = 1'b1;
    #1 check("R8 drive resumes", {driveHi, driveLo}, 2'b11);
    check("R9 valid low at write end", rdValid, 1'b0);
    shadow[10'h123] = 16'hC0DE;
    repeat (LAT) @(posedge clk);
    #2;
    check("R8 valid after write", rdValid, 1'b1);
    check("R8 reads just written", rdData, 16'hC0DE);
    idle();
  endtask

  task automatic t_latency();
    @(negedge clk);
    addrIn = 10'h001; selN = 1'b0; wrN = 1'b1; oeN = 1'b0; loN = 1'b0; hiN = 1'b0;
    repeat (LAT + 1) @(posedge clk);
    #2 check("R9 valid settled", rdValid, 1'b1);
    @(negedge clk);
    addrIn = 10'h3FF;
    #1 check("R9 valid drops same cycle", rdValid, 1'b0);
    repeat (LAT - 1) @(posedge clk);
    #2 check("R9 still settling", rdValid, 1'b0);
    @(posedge clk);
    #2 check("R9 valid after LAT edges", rdValid, 1'b1);
    check("R9 data new address", rdData, shadow[10'h3FF]);
    idle();
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_fullWords();
    t_laneWrites();
    t_laneReads();
    t_bothHigh();
    t_deselect();
    t_outDisabled();
    t_lastData();
    t_laneEnd();
    t_writeThenRead();
    t_latency();
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule